// File: doc/BRIEF.md
# Subcarrier Phase-Keyed Answer Transmitter

This block turns a short stream of answer bytes into the single modulation bit that drives a proximity card's load switch. The bit is a subcarrier at one sixteenth of the 13.56 MHz system clock (847.5 kHz). Data is carried by the subcarrier's phase, not by its level. A pulse on `start` launches an answer. The block first stays silent for a guard interval. It then sends an unmodulated subcarrier burst, which the reader uses as its phase reference. After that it shifts out the start-of-frame mark, one 10-bit character per data byte, two characters of Type B CRC, and the end-of-frame mark.

One elementary time unit (ETU) lasts eight subcarrier periods, which is 128 clocks. During an ETU that carries logic 1, the subcarrier has the same phase as the reference burst. During an ETU that carries logic 0, the subcarrier is inverted. As a result, every change of logic level shows up as a 180-degree phase flip on an ETU boundary.

Bytes arrive on a valid/ready stream and are accepted only while an answer is in progress. A one-byte holding register, which a byte can also bypass, lets the source stay a whole character ahead of the air interface. The data field ends in one of two ways: the source marks the final byte, or no byte is on hand when the next character would begin.

Top module: `ans_tx_bpsk`

## Requirements
- R1: Out of reset, and whenever no answer is in progress, `busy`, `mod_out` and `in_ready` are all low. A `start` pulse while idle makes `busy` high on the next clock.
- R2: For 2048 clocks (128 subcarrier periods) after the `start` clock, `mod_out` stays low while `busy` is high.
- R3: For the next 2048 clocks, `mod_out` is the reference subcarrier. Counting clocks from the `start` edge, it is high on the first 8 clocks of each 16-clock period and low on the last 8.
- R4: Each bit after the burst lasts 128 clocks. A logic-1 bit repeats the reference waveform. A logic-0 bit sends its exact complement.
- R5: The frame opens with 10 logic-0 ETUs followed by 2 logic-1 ETUs. It closes with the same 12-ETU pattern.
- R6: Each data byte is sent as 10 ETUs in this order: a 0, then the eight data bits least significant first, then a 1.
- R7: After the data, two more characters carry the CRC, low byte first. The CRC uses the reflected polynomial 8408h, starts at FFFFh, is run over the data bytes only, and is bit-inverted before it is sent.
- R8: `in_ready` is high only while an answer is in progress, the holding register is empty and the data field is still open. Accepting a byte with `in_last` high closes the data field.
- R9: If no byte is held or offered at a character boundary, the data field ends and the CRC follows. With no bytes at all, the CRC characters carry 00h and 00h. Once the field has closed, `in_ready` stays low for the rest of the answer, even if a byte is offered.
- R10: `busy` falls on the clock after the last ETU of the closing mark, 4096 + 128·(44 + 10·N) clocks after `start` for N data bytes. `mod_out` is low from then on.
- R11: A `start` pulse while an answer is in progress has no effect on the waveform or the frame length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 13.56 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an answer when idle |
| in_valid | input | 1 | Answer byte offered |
| in_data | input | 8 | Answer byte |
| in_last | input | 1 | Offered byte is the final data byte |
| in_ready | output | 1 | Answer byte accepted on this clock when valid |
| busy | output | 1 | Answer in progress, guard through closing mark |
| mod_out | output | 1 | Load-modulation waveform bit |

## Verification
A fault in the phase of the subcarrier divider shows up on `mod_out` as a waveform offset from its very first reference period, 2048 clocks after `start`. A fault in the bit shift register or the element sequencer leaves the waveform inverted for at least one whole ETU, so it is visible within 128 clocks of the affected bit. A fault in the CRC register stays hidden until the first CRC character, and then spoils at least one of its 20 ETUs. A fault in byte handling shows up in two ways: `in_ready` asserted outside the open data field, or a frame length that moves by exactly 1280 clocks per extra or missing character.

// File: rtl/ans_tx_pkg.sv
package ans_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GUARD,
        ST_SYNC,
        ST_BITS
    } tx_state_e;

    typedef enum logic [2:0] {
        EL_SOF,
        EL_CHAR,
        EL_CRCL,
        EL_CRCH,
        EL_EOF
    } tx_elem_e;

    typedef struct packed {
        logic [7:0] data;
        logic       last;
    } tx_byte_t;

    localparam int CHAR_LEN = 10;
    localparam int MARK_LEN = 12;
    localparam int SHIFT_W  = 12;

    // bit 0 leaves first: ten zeros, then two ones
    localparam logic [SHIFT_W-1:0] MARK_PATTERN = 12'b1100_0000_0000;

    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam logic [15:0] CRC_POLY = 16'h8408;

    function automatic logic [SHIFT_W-1:0] char_pattern(input logic [7:0] b);
        return {2'b00, 1'b1, b, 1'b0};
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/ans_tx_subcarrier.sv
module ans_tx_subcarrier #(
    parameter int SC_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sc_tick,
    output logic sc_wave
);
    localparam int DIV_W = $clog2(SC_DIV);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SC_DIV - 1);
    localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(SC_DIV / 2);

    logic [DIV_W-1:0] div;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div <= '0;
        end else if (div == DIV_LAST) begin
            div <= '0;
        end else begin
            div <= div + 1'b1;
        end
    end

    assign sc_tick = run && (div == DIV_LAST);
    assign sc_wave = (div < DIV_HALF);

endmodule

// File: rtl/ans_tx_bytebuf.sv
module ans_tx_bytebuf
    import ans_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       open_i,
    input  logic       close_i,
    input  logic       take_i,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       avail,
    output logic [7:0] head_data
);
    logic     field_open;
    logic     full;
    tx_byte_t held;
    logic     accept;

    assign in_ready  = field_open && !full;
    assign accept    = in_valid && in_ready;
    assign avail     = full || accept;
    assign head_data = full ? held.data : in_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            field_open <= 1'b0;
        end else if (close_i) begin
            field_open <= 1'b0;
        end else if (open_i) begin
            field_open <= 1'b1;
        end else if (accept && in_last) begin
            field_open <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= '0;
        end else if (accept && !take_i) begin
            full <= 1'b1;
            held <= '{data: in_data, last: in_last};
        end else if (take_i) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/ans_tx_seq.sv
module ans_tx_seq
    import ans_tx_pkg::*;
#(
    parameter int GUARD_SC = 128,
    parameter int SYNC_SC  = 128,
    parameter int ETU_SC   = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       sc_tick,
    input  logic       avail,
    input  logic [7:0] head_data,
    output logic       busy,
    output logic       active,
    output logic       level,
    output logic       take,
    output logic       close,
    output logic       frame_start,
    output tx_state_e  state
);
    localparam int MAX_SC = (GUARD_SC > SYNC_SC) ?
                            ((GUARD_SC > ETU_SC) ? GUARD_SC : ETU_SC) :
                            ((SYNC_SC > ETU_SC) ? SYNC_SC : ETU_SC);
    localparam int CNT_W  = $clog2(MAX_SC + 1);

    logic [CNT_W-1:0]   sc_cnt;
    logic [SHIFT_W-1:0] shreg;
    logic [3:0]         bits_left;
    tx_elem_e           elem;
    logic [15:0]        crc;
    logic               bit_end;
    logic               elem_end;
    logic               data_slot;

    assign bit_end     = (state == ST_BITS) && sc_tick && (sc_cnt == CNT_W'(ETU_SC - 1));
    assign elem_end    = bit_end && (bits_left == 4'd1);
    assign data_slot   = (elem == EL_SOF) || (elem == EL_CHAR);
    assign take        = elem_end && data_slot && avail;
    assign close       = elem_end && data_slot && !avail;
    assign frame_start = (state == ST_IDLE) && start;
    assign busy        = (state != ST_IDLE);
    assign active      = (state == ST_SYNC) || (state == ST_BITS);
    assign level       = (state == ST_BITS) ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sc_cnt    <= '0;
            shreg     <= '0;
            bits_left <= '0;
            elem      <= EL_SOF;
            crc       <= CRC_SEED;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_GUARD;
                        sc_cnt <= '0;
                        crc    <= CRC_SEED;
                    end
                end
                ST_GUARD: begin
                    if (sc_tick) begin
                        if (sc_cnt == CNT_W'(GUARD_SC - 1)) begin
                            state  <= ST_SYNC;
                            sc_cnt <= '0;
                        end else begin
                            sc_cnt <= sc_cnt + 1'b1;
                        end
                    end
                end
                ST_SYNC: begin
                    if (sc_tick) begin
                        if (sc_cnt == CNT_W'(SYNC_SC - 1)) begin
                            state     <= ST_BITS;
                            sc_cnt    <= '0;
                            shreg     <= MARK_PATTERN;
                            bits_left <= 4'(MARK_LEN);
                            elem      <= EL_SOF;
                        end else begin
                            sc_cnt <= sc_cnt + 1'b1;
                        end
                    end
                end
                ST_BITS: begin
                    if (sc_tick) begin
                        if (sc_cnt == CNT_W'(ETU_SC - 1)) begin
                            sc_cnt <= '0;
                            if (bits_left == 4'd1) begin
                                unique case (elem)
                                    EL_SOF, EL_CHAR: begin
                                        bits_left <= 4'(CHAR_LEN);
                                        if (avail) begin
                                            shreg <= char_pattern(head_data);
                                            crc   <= crc_step(crc, head_data);
                                            elem  <= EL_CHAR;
                                        end else begin
                                            shreg <= char_pattern(~crc[7:0]);
                                            elem  <= EL_CRCL;
                                        end
                                    end
                                    EL_CRCL: begin
                                        shreg     <= char_pattern(~crc[15:8]);
                                        bits_left <= 4'(CHAR_LEN);
                                        elem      <= EL_CRCH;
                                    end
                                    EL_CRCH: begin
                                        shreg     <= MARK_PATTERN;
                                        bits_left <= 4'(MARK_LEN);
                                        elem      <= EL_EOF;
                                    end
                                    default: begin
                                        state <= ST_IDLE;
                                    end
                                endcase
                            end else begin
                                shreg     <= shreg >> 1;
                                bits_left <= bits_left - 1'b1;
                            end
                        end else begin
                            sc_cnt <= sc_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ans_tx_bpsk.sv
module ans_tx_bpsk
    import ans_tx_pkg::*;
#(
    parameter int SC_DIV   = 16,
    parameter int ETU_SC   = 8,
    parameter int GUARD_SC = 128,
    parameter int SYNC_SC  = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       busy,
    output logic       mod_out
);
    logic       sc_tick;
    logic       sc_wave;
    logic       avail;
    logic [7:0] head_data;
    logic       active;
    logic       level;
    logic       take;
    logic       close;
    logic       frame_start;
    tx_state_e  seq_state;

    ans_tx_subcarrier #(.SC_DIV(SC_DIV)) i_subcarrier (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .sc_tick (sc_tick),
        .sc_wave (sc_wave)
    );

    ans_tx_bytebuf i_bytebuf (
        .clk       (clk),
        .rst       (rst),
        .open_i    (frame_start),
        .close_i   (close),
        .take_i    (take),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .avail     (avail),
        .head_data (head_data)
    );

    ans_tx_seq #(
        .GUARD_SC (GUARD_SC),
        .SYNC_SC  (SYNC_SC),
        .ETU_SC   (ETU_SC)
    ) i_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .sc_tick     (sc_tick),
        .avail       (avail),
        .head_data   (head_data),
        .busy        (busy),
        .active      (active),
        .level       (level),
        .take        (take),
        .close       (close),
        .frame_start (frame_start),
        .state       (seq_state)
    );

    // logic 0 inverts the subcarrier against the reference burst
    assign mod_out = active && (sc_wave ^ !level);

endmodule

// File: rtl/ans_tx_bpsk_chk.sv
module ans_tx_bpsk_chk
    import ans_tx_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      start,
    input logic      in_ready,
    input logic      busy,
    input logic      mod_out,
    input tx_state_e state
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mod_out && !in_ready));

    // R1
    launch_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    // R11
    no_spurious_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);

    // R8
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> busy);

    // R2
    guard_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GUARD) |-> !mod_out);

    // R10
    drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !mod_out);

endmodule

bind ans_tx_bpsk ans_tx_bpsk_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_ready (in_ready),
    .busy     (busy),
    .mod_out  (mod_out),
    .state    (seq_state)
);

// File: tb/test_ans_tx_bpsk.sv
module test_ans_tx_bpsk;

    localparam int CLK_PERIOD = 74;
    localparam int ETU_CLK    = 128;
    localparam int GUARD_CLK  = 2048;
    localparam int SYNC_CLK   = 2048;
    localparam int WATCHDOG   = 190000;

    typedef struct packed {
        logic [3:0]  n;
        logic [31:0] bytes;
        logic [7:0]  etus;
    } vec_t;

    // byte i sits at bytes[8*i +: 8]; etus = 44 + 10*n (R10)
    localparam vec_t VECS [4] = '{
        '{4'd1, 32'h0000_00A5, 8'd54},
        '{4'd2, 32'h0000_FF00, 8'd64},
        '{4'd3, 32'h0056_3412, 8'd74},
        '{4'd4, 32'hEFBE_ADDE, 8'd84}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       busy;
    logic       mod_out;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    logic exp_bits [0:199];
    int  exp_len;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ans_tx_bpsk i_ans_tx_bpsk (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .in_ready (in_ready),
        .busy     (busy),
        .mod_out  (mod_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_crc(input int n, input logic [31:0] bytes);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {8'h00, bytes[8*i +: 8]};
            for (int b = 0; b < 8; b++) begin
                if (c[0]) c = (c >> 1) ^ 16'h8408;
                else      c = c >> 1;
            end
        end
        return ~c;
    endfunction

    task automatic push_char(input logic [7:0] b);
        exp_bits[exp_len] = 1'b0;
        exp_len++;
        for (int i = 0; i < 8; i++) begin
            exp_bits[exp_len] = b[i];
            exp_len++;
        end
        exp_bits[exp_len] = 1'b1;
        exp_len++;
    endtask

    task automatic push_mark();
        for (int i = 0; i < 12; i++) begin
            exp_bits[exp_len] = (i >= 10);
            exp_len++;
        end
    endtask

    task automatic build(input int n, input logic [31:0] bytes);
        logic [15:0] c;
        c = model_crc(n, bytes);
        exp_len = 0;
        push_mark();
        for (int i = 0; i < n; i++) push_char(bytes[8*i +: 8]);
        push_char(c[7:0]);
        push_char(c[15:8]);
        push_mark();
    endtask

    task automatic producer(input int n, input logic [31:0] bytes, input bit give_last);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = bytes[8*i +: 8];
            in_last  = give_last && (i == n - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic monitor(input int n, input int etus, input bit offer_late);
        int    bad;
        int    rdy_bad;
        int    first_act;
        int    first_exp;
        int    kk;
        int    data_end;
        logic  expv;
        string tag;
        // R2: guard interval silent
        bad = 0;
        for (int k = 0; k < GUARD_CLK; k++) begin
            if (mod_out !== 1'b0 || busy !== 1'b1) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R2", "guard samples off", bad, 0);
        // R3: reference burst; R11: stray start pulse inside it
        bad = 0;
        first_act = 0;
        first_exp = 0;
        for (int k = 0; k < SYNC_CLK; k++) begin
            kk = GUARD_CLK + k;
            start = (k == 300);
            expv = ((kk % 16) < 8);
            if (mod_out !== expv || busy !== 1'b1) begin
                if (bad == 0) begin
                    first_act = mod_out;
                    first_exp = expv;
                end
                bad++;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(bad == 0, "R3", "reference burst", first_act, first_exp);
        // R4 waveform per ETU, tagged by element
        data_end = 12 + 10 * n;
        rdy_bad = 0;
        for (int j = 0; j < etus; j++) begin
            bad = 0;
            first_act = 0;
            first_exp = 0;
            if (offer_late && j == data_end) begin
                in_valid = 1'b1;
                in_data  = 8'h3C;
                in_last  = 1'b1;
            end
            for (int c = 0; c < ETU_CLK; c++) begin
                kk = GUARD_CLK + SYNC_CLK + ETU_CLK * j + c;
                if (j == 5) start = (c == 64);
                expv = ((kk % 16) < 8) ^ !exp_bits[j];
                if (mod_out !== expv || busy !== 1'b1) begin
                    if (bad == 0) begin
                        first_act = mod_out;
                        first_exp = expv;
                    end
                    bad++;
                end
                if (c == 0 && j >= data_end && in_ready !== 1'b0) rdy_bad++;
                @(negedge clk);
            end
            if (j < 12)                 tag = "R5 opening mark";
            else if (j < data_end)      tag = "R6 data char";
            else if (j < data_end + 20) tag = "R7 crc char";
            else                        tag = "R5 closing mark";
            check(bad == 0, tag, $sformatf("R4 ETU %0d", j), first_act, first_exp);
        end
        start = 1'b0;
        check(rdy_bad == 0, "R8", "in_ready after data field", rdy_bad, 0);
        if (offer_late) check(rdy_bad == 0, "R9", "late byte refused", rdy_bad, 0);
        // R10 frame end; R11 stray starts had no effect on length
        check(busy === 1'b0 && mod_out === 1'b0, "R10/R11", "busy,mod after EOF",
              {busy, mod_out}, 0);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_frame(input int n, input logic [31:0] bytes, input int etus,
                             input bit give_last, input bit offer_late);
        build(n, bytes);
        check(exp_len == etus, "R10", "bench frame length", exp_len, etus);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            producer(n, bytes, give_last);
            monitor(n, etus, offer_late);
        join
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy === 1'b0, "R1", "busy after reset", busy, 0);
        check(mod_out === 1'b0, "R1", "mod_out after reset", mod_out, 0);
        check(in_ready === 1'b0, "R1", "in_ready after reset", in_ready, 0);
        // R8: byte offered while idle is not taken
        in_valid = 1'b1;
        in_data  = 8'h77;
        @(negedge clk);
        check(in_ready === 1'b0 && busy === 1'b0, "R8", "idle refuses byte",
              {in_ready, busy}, 0);
        in_valid = 1'b0;

        foreach (VECS[v]) begin
            run_frame(int'(VECS[v].n), VECS[v].bytes, int'(VECS[v].etus), 1'b1, 1'b0);
        end

        // R9: zero-byte answer, CRC characters 00h 00h
        check(model_crc(0, 32'h0) == 16'h0000, "R9", "empty crc model", model_crc(0, 32'h0), 0);
        run_frame(0, 32'h0, 44, 1'b0, 1'b0);

        // R9: source stops without last flag after two bytes, late byte refused
        run_frame(2, 32'h0000_C381, 64, 1'b0, 1'b1);

        summary();
    end

endmodule